// File: doc/BRIEF.md
# NAND Copy-Back and Block-Erase Sequencer

This block sits on the host side of an 8-bit NAND flash bus and runs two operations on request. A copy-back moves one page (528 bytes) from a source page to a target page entirely inside the flash, so no data bytes travel on the bus. A block erase sets every bit of one block to one. The host raises `start` for one clock with an operation code and two page addresses. The block answers with a one-clock `done` pulse, along with a `rejected` flag and a `failed` flag.

On the flash side the block drives the chip enable, command-latch and address-latch lines, the write and read strobes and the output byte. It samples the ready/busy line and the input byte. A copy-back runs in two phases. The first phase is a source read. The block then waits for ready/busy to go high. The second phase is the program into the target page. Each operation ends with a status read, and bit 0 of that status byte is the pass/fail result.

The block keeps one flag per erase block that marks the block as a copy-back target. A partial-program check on a page of a marked block is refused until that block has been erased successfully.

Top module: `nand_cb_erase_seq`

## Requirements
- R1: Op code 0 (copy-back) produces, in order, the following write strobes. Command 00h with CLE high. Three address bytes with ALE high: src[7:0], src[16:9], src[24:17]. A ready/busy wait. Command 8Ah. Three target address bytes in the same layout. Command 10h. A ready/busy wait. Command 70h. Then one read strobe.
- R2: After the last write strobe of each phase, no write or read strobe starts until at least BUSY_DLY clocks have passed and `nand_rb` has been sampled high.
- R3: A copy-back whose address bit 24 differs between src and tgt finishes with `done` on the next clock, `rejected`=1 and `failed`=0, and no strobe occurs.
- R4: Op code 1 (erase) produces, in order: command ERASE_SETUP (default 60h); address byte {tgt[16:14], 5'b00000}; address byte tgt[24:17]; command ERASE_GO (default D0h); a ready/busy wait; command 70h; then one read strobe. The byte tgt[7:0] is never sent.
- R5: For a copy-back or erase that is not rejected, `failed` equals bit 0 of the status byte captured on the read strobe, and `rejected` is 0.
- R6: Every write strobe keeps `nand_we_n` low for exactly STROBE_CLKS clocks, and CLE, ALE and the output byte stay stable while it is low. Every read strobe keeps `nand_re_n` low for exactly STROBE_CLKS clocks. CLE and ALE are never high together, and the two strobes are never low together.
- R7: Op code 2 (partial-program check) produces no strobe. It reports `rejected`=1 when the block tgt[24:14] has been the target of a copy-back, and `rejected`=0 otherwise.
- R8: An erase with status bit 0 clear removes the copy-back mark of block tgt[24:14]. An erase that reports a failure leaves the mark set.
- R9: A `start` pulse while an operation is running is ignored. Exactly one `done` is produced, and it belongs to the first request.
- R10: While reset is applied, `nand_we_n`, `nand_re_n` and `nand_ce_n` are high, and `nand_cle`, `nand_ale` and `done` are low. `nand_ce_n` is low whenever a strobe is active.
- R11: Op code 3 is reserved. It is rejected on the next clock with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock request pulse, accepted only when idle |
| op | input | 2 | 0 copy-back, 1 erase, 2 partial-program check, 3 reserved |
| src_addr | input | 25 | Copy-back source page address |
| tgt_addr | input | 25 | Copy-back target, erase block or checked page address |
| done | output | 1 | One-clock completion pulse |
| rejected | output | 1 | Request refused; valid from `done` until the next `done` |
| failed | output | 1 | Status bit 0 of the finished operation |
| nand_ce_n | output | 1 | Chip enable, low during an operation |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the bus |
| nand_io_oe | output | 1 | Output-drive enable for `nand_io_out` |
| nand_io_in | input | 8 | Byte read from the bus |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
A wrong step index or a wrong operation latch shows up at the next write strobe as a wrong byte or a wrong latch line. That is a few clocks after the fault, and the bench compares every logged strobe against a list it builds from the addresses. A wait state that leaves too early shows up as a strobe falling while the bench's ready/busy model is still low. A corrupted mark flag stays hidden until the next partial-program check on that block, so the bench interleaves copy-backs, erases that pass, erases that fail, and checks on both marked and unmarked blocks.

// File: rtl/nseq_pkg.sv
// Shared types and constants for the copy-back / erase sequencer.
// Assumes a 25-bit page address: A0-A7 column, A8 chosen by the read
// command, A9-A24 page, with A14 and up naming the erase block.
package nseq_pkg;
    localparam int ADDR_W  = 25;
    localparam int BLK_LSB = 14;
    localparam int IDX_W   = ADDR_W - BLK_LSB;
    localparam int NBLK    = 1 << IDX_W;
    localparam int STEP_W  = 4;

    localparam logic [7:0] OPC_READ0   = 8'h00;
    localparam logic [7:0] OPC_COPY    = 8'h8A;
    localparam logic [7:0] OPC_PROG_GO = 8'h10;
    localparam logic [7:0] OPC_STATUS  = 8'h70;

    typedef enum logic [1:0] {
        OP_COPY  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PCHK  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        K_CMD  = 3'd0,
        K_ADDR = 3'd1,
        K_WAIT = 3'd2,
        K_READ = 3'd3,
        K_END  = 3'd4
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] val;
    } step_t;
endpackage

// File: rtl/nseq_step_rom.sv
// Decodes (operation, step index) into the next bus action and its byte.
// Purely combinational; assumes the address layout of nseq_pkg.
module nseq_step_rom
    import nseq_pkg::*;
#(
    parameter logic [7:0] ERASE_SETUP = 8'h60,
    parameter logic [7:0] ERASE_GO    = 8'hD0
) (
    input  op_e                op,
    input  logic [STEP_W-1:0]  step,
    input  logic [ADDR_W-1:0]  src,
    input  logic [ADDR_W-1:0]  tgt,
    output step_t              act
);
    function automatic step_t mk(input kind_e k, input logic [7:0] v);
        step_t s;
        s.kind = k;
        s.val  = v;
        return s;
    endfunction

    // A8 is carried by the read opcode, never by an address byte.
    logic unused_a8;
    assign unused_a8 = src[8] ^ tgt[8];

    // Step table per operation.
    always_comb begin
        act = mk(K_END, 8'h00);
        case (op)
            OP_COPY: begin
                case (step)
                    4'd0:  act = mk(K_CMD,  OPC_READ0);
                    4'd1:  act = mk(K_ADDR, src[7:0]);
                    4'd2:  act = mk(K_ADDR, src[16:9]);
                    4'd3:  act = mk(K_ADDR, src[24:17]);
                    4'd4:  act = mk(K_WAIT, 8'h00);
                    4'd5:  act = mk(K_CMD,  OPC_COPY);
                    4'd6:  act = mk(K_ADDR, tgt[7:0]);
                    4'd7:  act = mk(K_ADDR, tgt[16:9]);
                    4'd8:  act = mk(K_ADDR, tgt[24:17]);
                    4'd9:  act = mk(K_CMD,  OPC_PROG_GO);
                    4'd10: act = mk(K_WAIT, 8'h00);
                    4'd11: act = mk(K_CMD,  OPC_STATUS);
                    4'd12: act = mk(K_READ, 8'h00);
                    default: act = mk(K_END, 8'h00);
                endcase
            end
            OP_ERASE: begin
                case (step)
                    4'd0: act = mk(K_CMD,  ERASE_SETUP);
                    4'd1: act = mk(K_ADDR, {tgt[16:14], 5'b00000});
                    4'd2: act = mk(K_ADDR, tgt[24:17]);
                    4'd3: act = mk(K_CMD,  ERASE_GO);
                    4'd4: act = mk(K_WAIT, 8'h00);
                    4'd5: act = mk(K_CMD,  OPC_STATUS);
                    4'd6: act = mk(K_READ, 8'h00);
                    default: act = mk(K_END, 8'h00);
                endcase
            end
            default: act = mk(K_END, 8'h00);
        endcase
    end
endmodule

// File: rtl/nseq_bus_phy.sv
// Executes one bus action per go pulse: a command or address write, a
// status read, or a ready/busy wait. Pulses done when the action ends.
// Assumes go arrives only while idle.
module nseq_bus_phy
    import nseq_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int BUSY_DLY    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  kind_e      kind,
    input  logic [7:0] val,
    input  logic       rb,
    input  logic [7:0] io_in,
    output logic       done,
    output logic [7:0] rd_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe
);
    localparam int CMAX = (STROBE_CLKS > BUSY_DLY) ? STROBE_CLKS : BUSY_DLY;
    localparam int CW   = $clog2(CMAX + 1);

    typedef enum logic [2:0] {P_IDLE, P_LOW, P_HOLD, P_DLY, P_RB} ph_e;
    ph_e           ph;
    logic [CW-1:0] cnt;

    // Strobe shaping, busy delay and ready/busy polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= P_IDLE;
            cnt     <= '0;
            cle     <= 1'b0;
            ale     <= 1'b0;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            io_out  <= 8'h00;
            io_oe   <= 1'b0;
            done    <= 1'b0;
            rd_byte <= 8'h00;
        end else begin
            done <= 1'b0;
            case (ph)
                P_IDLE: if (go) begin
                    cnt <= '0;
                    case (kind)
                        K_CMD, K_ADDR: begin
                            cle    <= (kind == K_CMD);
                            ale    <= (kind == K_ADDR);
                            io_out <= val;
                            io_oe  <= 1'b1;
                            we_n   <= 1'b0;
                            ph     <= P_LOW;
                        end
                        K_READ: begin
                            re_n <= 1'b0;
                            ph   <= P_LOW;
                        end
                        K_WAIT:  ph <= P_DLY;
                        default: done <= 1'b1;
                    endcase
                end
                P_LOW: begin
                    if (cnt == CW'(STROBE_CLKS - 1)) begin
                        if (!re_n) rd_byte <= io_in;
                        we_n <= 1'b1;
                        re_n <= 1'b1;
                        ph   <= P_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                P_HOLD: begin
                    cle   <= 1'b0;
                    ale   <= 1'b0;
                    io_oe <= 1'b0;
                    done  <= 1'b1;
                    ph    <= P_IDLE;
                end
                P_DLY: begin
                    if (cnt == CW'(BUSY_DLY - 1)) ph <= P_RB;
                    else cnt <= cnt + 1'b1;
                end
                P_RB: if (rb) begin
                    done <= 1'b1;
                    ph   <= P_IDLE;
                end
                default: ph <= P_IDLE;
            endcase
        end
    end

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
    p_rb_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(ph == P_RB)) |-> $past(rb));
endmodule

// File: rtl/nseq_block_marks.sv
// One flag per erase block marking blocks that received a copy-back.
// Set and clear share one write index; reads are combinational.
module nseq_block_marks #(
    parameter int IDX_BITS = 11,
    localparam int NFLAG   = 1 << IDX_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic                rd_flag
);
    logic [NFLAG-1:0] flags;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // Per-block flag update.
        always_ff @(posedge clk) begin
            if (!rst_n)                                         flags[g] <= 1'b0;
            else if (set_en && wr_idx == IDX_BITS'(g))          flags[g] <= 1'b1;
            else if (clr_en && wr_idx == IDX_BITS'(g))          flags[g] <= 1'b0;
        end
    end

    assign rd_flag = flags[rd_idx];

    p_mark_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> flags[$past(wr_idx)]);
    p_mark_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> !flags[$past(wr_idx)]);
endmodule

// File: rtl/nand_cb_erase_seq.sv
// Top of the copy-back / erase sequencer. Accepts one request at a time,
// walks the step table through the bus engine, captures status bit 0 and
// maintains the copy-back marks. Assumes start is a single-clock pulse.
module nand_cb_erase_seq
    import nseq_pkg::*;
#(
    parameter int         STROBE_CLKS = 2,
    parameter int         BUSY_DLY    = 3,
    parameter logic [7:0] ERASE_SETUP = 8'h60,
    parameter logic [7:0] ERASE_GO    = 8'hD0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  op,
    input  logic [24:0] src_addr,
    input  logic [24:0] tgt_addr,
    output logic        done,
    output logic        rejected,
    output logic        failed,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic        nand_rb
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_e;

    seq_e               state;
    op_e                op_q;
    logic [STEP_W-1:0]  step;
    logic [ADDR_W-1:0]  src_q, tgt_q;
    logic               stat_fail, done_q, rej_q, fail_q;
    step_t              cur;
    logic               go, phy_done, mark_hit, mark_set, mark_clr, plane_diff;
    logic [7:0]         phy_rd;
    logic               unused_stat;

    assign unused_stat = ^phy_rd[7:1];
    assign plane_diff  = src_addr[ADDR_W-1] ^ tgt_addr[ADDR_W-1];
    assign go          = (state == S_ISSUE) && (cur.kind != K_END);
    assign mark_set    = (state == S_ISSUE) && (cur.kind == K_END) && (op_q == OP_COPY);
    assign mark_clr    = (state == S_ISSUE) && (cur.kind == K_END) && (op_q == OP_ERASE) && !stat_fail;
    assign nand_ce_n   = (state == S_IDLE);
    assign done        = done_q;
    assign rejected    = rej_q;
    assign failed      = fail_q;

    nseq_step_rom #(.ERASE_SETUP(ERASE_SETUP), .ERASE_GO(ERASE_GO)) u_rom (
        .op(op_q), .step(step), .src(src_q), .tgt(tgt_q), .act(cur)
    );

    nseq_bus_phy #(.STROBE_CLKS(STROBE_CLKS), .BUSY_DLY(BUSY_DLY)) u_phy (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(cur.kind), .val(cur.val),
        .rb(nand_rb), .io_in(nand_io_in), .done(phy_done), .rd_byte(phy_rd),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .io_out(nand_io_out), .io_oe(nand_io_oe)
    );

    nseq_block_marks #(.IDX_BITS(IDX_W)) u_marks (
        .clk(clk), .rst_n(rst_n), .set_en(mark_set), .clr_en(mark_clr),
        .wr_idx(tgt_q[ADDR_W-1:BLK_LSB]), .rd_idx(tgt_addr[ADDR_W-1:BLK_LSB]),
        .rd_flag(mark_hit)
    );

    // Request acceptance, step walking and result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op_q      <= OP_COPY;
            step      <= '0;
            src_q     <= '0;
            tgt_q     <= '0;
            stat_fail <= 1'b0;
            done_q    <= 1'b0;
            rej_q     <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    op_q      <= op_e'(op);
                    src_q     <= src_addr;
                    tgt_q     <= tgt_addr;
                    step      <= '0;
                    stat_fail <= 1'b0;
                    case (op_e'(op))
                        OP_COPY: begin
                            if (plane_diff) begin
                                done_q <= 1'b1;
                                rej_q  <= 1'b1;
                                fail_q <= 1'b0;
                            end else begin
                                state <= S_ISSUE;
                            end
                        end
                        OP_ERASE: state <= S_ISSUE;
                        OP_PCHK: begin
                            done_q <= 1'b1;
                            rej_q  <= mark_hit;
                            fail_q <= 1'b0;
                        end
                        default: begin
                            done_q <= 1'b1;
                            rej_q  <= 1'b1;
                            fail_q <= 1'b0;
                        end
                    endcase
                end
                S_ISSUE: begin
                    if (cur.kind == K_END) begin
                        done_q <= 1'b1;
                        rej_q  <= 1'b0;
                        fail_q <= stat_fail;
                        state  <= S_IDLE;
                    end else begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: if (phy_done) begin
                    if (cur.kind == K_READ) stat_fail <= phy_rd[0];
                    step  <= step + 1'b1;
                    state <= S_ISSUE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_plane_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && op == 2'd0 && plane_diff) |=> (done && rejected));
    p_strobe_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> nand_ce_n);
endmodule

// File: tb/nand_cb_erase_seq_test.sv
module nand_cb_erase_seq_test;
    localparam int STROBE = 2;
    localparam int DLY    = 3;
    localparam int BUSY_T = 12;

    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [1:0]  op;
    logic [24:0] src, tgt;
    logic        done, rejected, failed;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb;

    always #4 clk = ~clk;

    nand_cb_erase_seq #(.STROBE_CLKS(STROBE), .BUSY_DLY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_addr(src),
        .tgt_addr(tgt), .done(done), .rejected(rejected), .failed(failed),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Flash bus model: logs write strobes, models busy time, checks widths.
    int         log_n = 0, re_pulses = 0, viol = 0, width_err = 0, done_cnt = 0;
    int         busy_cnt = 0, we_lo = 0, re_lo = 0, addr_seen = 0;
    logic       prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] last_cmd = 8'hFF, status_r = 8'h00;
    logic [9:0] log_e [0:31];

    assign nand_rb    = (busy_cnt == 0);
    assign nand_io_in = status_r;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_we = 1'b1; prev_re = 1'b1; busy_cnt = 0; we_lo = 0; re_lo = 0;
        end else begin
            if (busy_cnt > 0) busy_cnt--;
            if (done) done_cnt++;
            if (!nand_we_n) begin
                if (prev_we && busy_cnt != 0) viol++;
                we_lo++;
            end else if (!prev_we) begin
                if (we_lo != STROBE) width_err++;
                we_lo = 0;
                if (log_n < 32) log_e[log_n] = {nand_cle, nand_ale, nand_io_out};
                log_n++;
                if (nand_cle) begin
                    last_cmd  = nand_io_out;
                    addr_seen = 0;
                    if (nand_io_out == 8'h10 || nand_io_out == 8'hD0) busy_cnt = BUSY_T;
                end else if (nand_ale) begin
                    addr_seen++;
                    if (last_cmd == 8'h00 && addr_seen == 3) busy_cnt = BUSY_T;
                end
            end
            if (!nand_re_n) begin
                if (prev_re && busy_cnt != 0) viol++;
                re_lo++;
            end else if (!prev_re) begin
                if (re_lo != STROBE) width_err++;
                re_lo = 0;
                re_pulses++;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog R9: actual %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected write-strobe log entry {cle, ale, byte}.
    function automatic logic [9:0] exp_ent(input logic [1:0] o, input logic [24:0] s,
                                           input logic [24:0] t, input int i);
        if (o == 2'd0) begin
            case (i)
                0: return {2'b10, 8'h00};
                1: return {2'b01, s[7:0]};
                2: return {2'b01, s[16:9]};
                3: return {2'b01, s[24:17]};
                4: return {2'b10, 8'h8A};
                5: return {2'b01, t[7:0]};
                6: return {2'b01, t[16:9]};
                7: return {2'b01, t[24:17]};
                8: return {2'b10, 8'h10};
                default: return {2'b10, 8'h70};
            endcase
        end
        case (i)
            0: return {2'b10, 8'h60};
            1: return {2'b01, t[16:14], 5'b00000};
            2: return {2'b01, t[24:17]};
            3: return {2'b10, 8'hD0};
            default: return {2'b10, 8'h70};
        endcase
    endfunction

    function automatic int exp_len(input logic [1:0] o, input logic [24:0] s, input logic [24:0] t);
        if (o == 2'd0 && s[24] == t[24]) return 10;
        if (o == 2'd1) return 5;
        return 0;
    endfunction

    function automatic string op_tag(input logic [1:0] o, input logic [24:0] s, input logic [24:0] t);
        if (o == 2'd0) return (s[24] != t[24]) ? "R3" : "R1";
        if (o == 2'd1) return "R4";
        if (o == 2'd2) return "R7";
        return "R11";
    endfunction

    // Issue one request and wait for done; returns whether done was seen.
    task automatic run_op(input logic [1:0] o, input logic [24:0] s, input logic [24:0] t,
                          input logic [7:0] stv, output bit got);
        @(negedge clk);
        log_n = 0; viol = 0; width_err = 0; re_pulses = 0; done_cnt = 0;
        status_r = stv; op = o; src = s; tgt = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        for (int i = 0; i < 2000 && !got; i++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    // Full comparison of one request against the requirements.
    task automatic check_op(input logic [1:0] o, input logic [24:0] s, input logic [24:0] t,
                            input logic [7:0] stv, input bit exp_rej);
        bit   got;
        bit   exp_fail;
        int   len, bad;
        string tg;
        tg = op_tag(o, s, t);
        run_op(o, s, t, stv, got);
        chk(got, {tg, " done seen"}, got, 1);
        chk(rejected == exp_rej, {tg, " rejected"}, rejected, exp_rej);
        exp_fail = !exp_rej && (o < 2'd2) && stv[0];
        chk(failed == exp_fail, "R5 failed flag", failed, exp_fail);
        repeat (3) @(negedge clk);
        len = exp_len(o, s, t);
        chk(log_n == len, {tg, " strobe count"}, log_n, len);
        bad = 0;
        for (int i = 0; i < len && i < log_n; i++) begin
            if (log_e[i] !== exp_ent(o, s, t, i)) begin
                bad++;
                $display("FAIL %s entry %0d: actual %0h expected %0h", tg, i, log_e[i], exp_ent(o, s, t, i));
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
        chk(re_pulses == ((len > 0) ? 1 : 0), "R5 status read count", re_pulses, (len > 0) ? 1 : 0);
        chk(viol == 0, "R2 strobe during busy", viol, 0);
        chk(width_err == 0, "R6 strobe width", width_err, 0);
        chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [24:0] src;
        logic [24:0] tgt;
        logic [7:0]  stat;
        logic        rej;
    } vec_t;

    localparam vec_t VT [0:7] = '{
        '{2'd0, 25'h00ABCDE, 25'h0123456, 8'hE0, 1'b0},
        '{2'd0, 25'h1FEDCBA, 25'h1000200, 8'hE1, 1'b0},
        '{2'd0, 25'h0000100, 25'h1000100, 8'h00, 1'b1},
        '{2'd1, 25'h0000000, 25'h1F3FFFF, 8'hE0, 1'b0},
        '{2'd1, 25'h0000000, 25'h0004000, 8'h01, 1'b0},
        '{2'd3, 25'h0000000, 25'h0000000, 8'h00, 1'b1},
        '{2'd2, 25'h0000000, 25'h0120000, 8'h00, 1'b1},
        '{2'd2, 25'h0000000, 25'h0200000, 8'h00, 1'b0}
    };

    initial begin
        bit got;
        rst_n = 1'b0; start = 1'b0; op = 2'd0; src = '0; tgt = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(nand_we_n && nand_re_n && nand_ce_n, "R10 strobes/ce high in reset",
            {nand_we_n, nand_re_n, nand_ce_n}, 3'b111);
        chk(!nand_cle && !nand_ale && !done, "R10 latches/done low in reset",
            {nand_cle, nand_ale, done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 8; v++)
            check_op(VT[v].op, VT[v].src, VT[v].tgt, VT[v].stat, VT[v].rej);

        // R8: a passing erase clears the mark of block 0x48
        check_op(2'd1, 25'h0, 25'h0123456, 8'h00, 1'b0);
        check_op(2'd2, 25'h0, 25'h0120000, 8'h00, 1'b0);
        // R8: a failing erase keeps the mark of block 0x400
        check_op(2'd1, 25'h0, 25'h1000200, 8'h01, 1'b0);
        check_op(2'd2, 25'h0, 25'h1000200, 8'h00, 1'b1);

        // R9: a second start while an erase runs is ignored
        @(negedge clk);
        log_n = 0; done_cnt = 0; viol = 0; status_r = 8'h00;
        op = 2'd1; src = '0; tgt = 25'h0004000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op = 2'd0; src = 25'h0000000; tgt = 25'h1000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        for (int i = 0; i < 2000 && !got; i++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
        chk(got && !rejected, "R9 first request completes", {got, rejected}, 2'b10);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R9 done count", done_cnt, 1);
        chk(log_n == 5, "R9 only erase strobes", log_n, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule